// File: doc/BRIEF.md
# Compare and Branch Condition Unit

This block sits beside the integer datapath of a small processor and resolves conditional branches. A compare operation presents two 32-bit register values with a one-cycle strobe; on the next clock edge the unit holds a 5-bit condition-code register. That register records either equality alone, or the signed and the unsigned ordering of the two operands together.

A later branch operation presents a 4-bit condition selector, the address of the branch instruction and a 10-bit signed offset counted in halfwords. From the registered condition code the unit answers, within the same cycle, whether the branch is taken and which address comes next. A selector outside the defined set raises an illegal flag and never branches. Register file access, instruction fetch and the program counter itself are outside this block.

Top module: `cbu_core`

## Requirements
- R1: While reset is asserted (rst_n low) and after its release, the condition-code output `cc_flags` reads 5'b00000 until the first compare strobe.
- R2: When `cmp_en` is high at a rising clock edge, `cc_flags` takes the new value at that edge, with bit positions fixed as: bit 0 signed greater, bit 1 signed less, bit 2 equal, bit 3 unsigned greater, bit 4 unsigned less (operand A compared against operand B).
- R3: If the two operands are equal, the loaded value is exactly 5'b00100; no ordering bit is set.
- R4: If the operands differ, bit 2 is clear and exactly one of bits 0/1 and exactly one of bits 3/4 are set, from the two's-complement and the unsigned ordering respectively.
- R5: With `cmp_en` low at a clock edge, `cc_flags` keeps its value.
- R6: Selector codes 0..9 mean, in order: equal, not equal, signed less, signed greater, unsigned less, unsigned greater, signed greater-or-equal, signed less-or-equal, unsigned greater-or-equal, unsigned less-or-equal; `br_taken` is high when `br_en` is high and the chosen condition holds.
- R7: Each or-equal condition (codes 6..9) holds when its ordering bit or the equal bit is set.
- R8: A taken branch drives `br_target` = `pc_in` + 2 + (sign-extended `br_ofs` shifted left by one), modulo 2^32.
- R9: Whenever `br_taken` is low, `br_target` = `pc_in` + 2.
- R10: With `br_en` high and a selector of 10..15, `cond_bad` is high and `br_taken` is low.
- R11: With `br_en` low, both `br_taken` and `cond_bad` are low.
- R12: Branch evaluation uses the registered condition code; a compare strobed in the same cycle as a branch does not affect that branch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | 32 | First compare operand |
| opnd_b | input | 32 | Second compare operand |
| cmp_en | input | 1 | Compare strobe; loads the condition code |
| cond_sel | input | 4 | Branch condition selector |
| br_en | input | 1 | Branch strobe |
| pc_in | input | 32 | Address of the branch instruction |
| br_ofs | input | 10 | Signed halfword branch offset |
| cc_flags | output | 5 | Registered condition code |
| br_taken | output | 1 | Branch taken |
| br_target | output | 32 | Next instruction address |
| cond_bad | output | 1 | Illegal selector on a branch strobe |

## Verification
The condition-code register is the only state, so a wrong value shows at `cc_flags` on the first sampling after the faulty compare edge and, for branches, as a wrong `br_taken` and `br_target` in the very next branch cycle. A flag value that never arises from a real compare (equal together with an ordering bit, or two bits of one ordering pair) is caught in the cycle after the compare. Stale or spuriously updated flags show as soon as a hold cycle or a same-cycle compare-and-branch is compared against the reference.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    localparam int CC_W = 5;

    // condition-code bit positions (decoded by the branch evaluator)
    localparam int CC_SGT = 0;
    localparam int CC_SLT = 1;
    localparam int CC_EQ  = 2;
    localparam int CC_UGT = 3;
    localparam int CC_ULT = 4;

    typedef enum logic [3:0] {
        COND_EQ  = 4'd0,
        COND_NE  = 4'd1,
        COND_SLT = 4'd2,
        COND_SGT = 4'd3,
        COND_ULT = 4'd4,
        COND_UGT = 4'd5,
        COND_SGE = 4'd6,
        COND_SLE = 4'd7,
        COND_UGE = 4'd8,
        COND_ULE = 4'd9
    } cond_e;

    localparam logic [3:0] COND_LAST = 4'd9;

    typedef struct packed {
        logic [CC_W-1:0] flags;
    } cc_state_t;

endpackage

// File: rtl/cbu_flag_gen.sv
module cbu_flag_gen
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              cmp_en,
    output logic [CC_W-1:0]   flags_q
);

    cc_state_t st_d, st_q;
    logic [CC_W-1:0] cmp_res;
    logic            same;

    always_comb begin
        same    = (opnd_a == opnd_b);
        cmp_res = '0;
        if (same) begin
            cmp_res[CC_EQ] = 1'b1;
        end else begin
            cmp_res[CC_SGT] = ($signed(opnd_a) >  $signed(opnd_b));
            cmp_res[CC_SLT] = ($signed(opnd_a) <  $signed(opnd_b));
            cmp_res[CC_UGT] = (opnd_a > opnd_b);
            cmp_res[CC_ULT] = (opnd_a < opnd_b);
        end
    end

    always_comb begin
        st_d = st_q;
        if (cmp_en) begin
            st_d.flags = cmp_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q = st_q.flags;

endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
    import cbu_pkg::*;
(
    input  logic [CC_W-1:0] flags,
    input  logic [3:0]      cond_sel,
    input  logic            br_en,
    output logic            taken,
    output logic            bad
);

    logic hit;
    logic legal;

    always_comb begin
        legal = (cond_sel <= COND_LAST);
        hit   = 1'b0;
        case (cond_sel)
            COND_EQ:  hit = flags[CC_EQ];
            COND_NE:  hit = !flags[CC_EQ];
            COND_SLT: hit = flags[CC_SLT];
            COND_SGT: hit = flags[CC_SGT];
            COND_ULT: hit = flags[CC_ULT];
            COND_UGT: hit = flags[CC_UGT];
            COND_SGE: hit = flags[CC_SGT] | flags[CC_EQ];
            COND_SLE: hit = flags[CC_SLT] | flags[CC_EQ];
            COND_UGE: hit = flags[CC_UGT] | flags[CC_EQ];
            COND_ULE: hit = flags[CC_ULT] | flags[CC_EQ];
            default:  hit = 1'b0;
        endcase
        taken = br_en & legal & hit;
        bad   = br_en & !legal;
    end

endmodule

// File: rtl/cbu_target_calc.sv
module cbu_target_calc #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 10
) (
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [OFS_W-1:0]  ofs,
    input  logic              taken,
    output logic [ADDR_W-1:0] target
);

    localparam int EXT_W = ADDR_W - OFS_W - 1;
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(2);

    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] next_pc;

    always_comb begin
        disp    = {{EXT_W{ofs[OFS_W-1]}}, ofs, 1'b0};
        next_pc = pc_in + INSN_BYTES;
        target  = taken ? (next_pc + disp) : next_pc;
    end

endmodule

// File: rtl/cbu_core.sv
module cbu_core
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              cmp_en,
    input  logic [3:0]        cond_sel,
    input  logic              br_en,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [OFS_W-1:0]  br_ofs,
    output logic [CC_W-1:0]   cc_flags,
    output logic              br_taken,
    output logic [ADDR_W-1:0] br_target,
    output logic              cond_bad
);

    logic [CC_W-1:0] flags_q;
    logic            taken_w;

    cbu_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .cmp_en  (cmp_en),
        .flags_q (flags_q)
    );

    cbu_cond_eval u_cond (
        .flags    (flags_q),
        .cond_sel (cond_sel),
        .br_en    (br_en),
        .taken    (taken_w),
        .bad      (cond_bad)
    );

    cbu_target_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_tgt (
        .pc_in  (pc_in),
        .ofs    (br_ofs),
        .taken  (taken_w),
        .target (br_target)
    );

    assign cc_flags = flags_q;
    assign br_taken = taken_w;

endmodule

// File: rtl/cbu_core_chk.sv
module cbu_core_chk
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic              cmp_en,
    input logic [3:0]        cond_sel,
    input logic              br_en,
    input logic [ADDR_W-1:0] pc_in,
    input logic [CC_W-1:0]   cc_flags,
    input logic              br_taken,
    input logic [ADDR_W-1:0] br_target,
    input logic              cond_bad
);

    // R3
    eq_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && opnd_a == opnd_b) |=> (cc_flags == 5'b00100));

    // R4
    neq_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && opnd_a != opnd_b) |=>
            (!cc_flags[CC_EQ] && $countones(cc_flags) == 2
             && $onehot0(cc_flags[1:0]) && $onehot0(cc_flags[4:3])));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(cc_flags));

    // R9
    fall_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_taken |-> (br_target == pc_in + ADDR_W'(2)));

    // R10
    bad_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_en && cond_sel > 4'd9) |-> (cond_bad && !br_taken));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !br_en |-> (!br_taken && !cond_bad));

endmodule

bind cbu_core cbu_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .cmp_en    (cmp_en),
    .cond_sel  (cond_sel),
    .br_en     (br_en),
    .pc_in     (pc_in),
    .cc_flags  (cc_flags),
    .br_taken  (br_taken),
    .br_target (br_target),
    .cond_bad  (cond_bad)
);

// File: tb/cbu_core_tb.sv
module cbu_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        cmp_en = 1'b0;
    logic [3:0]  cond_sel = '0;
    logic        br_en = 1'b0;
    logic [31:0] pc_in = '0;
    logic [9:0]  br_ofs = '0;
    logic [4:0]  cc_flags;
    logic        br_taken;
    logic [31:0] br_target;
    logic        cond_bad;

    int n_run = 0;
    int n_fail = 0;

    logic [4:0] m_flags = '0;
    string      flag_tag = "R1";

    always #5 clk = ~clk;

    cbu_core u_dut (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .cmp_en(cmp_en), .cond_sel(cond_sel), .br_en(br_en), .pc_in(pc_in),
        .br_ofs(br_ofs), .cc_flags(cc_flags), .br_taken(br_taken),
        .br_target(br_target), .cond_bad(cond_bad)
    );

    task automatic chk(input string tag, input string what,
                       input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference for a compare
    function automatic logic [4:0] ref_cmp(input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, ua, ub;
        logic [4:0] r;
        sa = longint'($signed(a)); sb = longint'($signed(b));
        ua = longint'({32'd0, a}); ub = longint'({32'd0, b});
        r = 5'b0;
        if (a == b) r = 5'b00100;
        else begin
            if (sa > sb) r = r | 5'b00001;
            if (sa < sb) r = r | 5'b00010;
            if (ua > ub) r = r | 5'b01000;
            if (ua < ub) r = r | 5'b10000;
        end
        return r;
    endfunction

    function automatic bit ref_hit(input logic [4:0] f, input int c);
        bit gt = f[0], lt = f[1], eq = f[2], gtu = f[3], ltu = f[4];
        case (c)
            0: return eq;
            1: return !eq;
            2: return lt;
            3: return gt;
            4: return ltu;
            5: return gtu;
            6: return gt || eq;
            7: return lt || eq;
            8: return gtu || eq;
            9: return ltu || eq;
            default: return 1'b0;
        endcase
    endfunction

    // one clock of stimulus, checked against the reference before the edge
    task automatic step(input logic [31:0] a, input logic [31:0] b, input bit cmp,
                        input int c, input bit br, input logic [31:0] pc,
                        input logic [9:0] ofs, input string btag);
        bit exp_tk, exp_bad;
        longint d;
        logic [31:0] exp_tgt;
        string ttag;
        @(negedge clk);
        opnd_a = a; opnd_b = b; cmp_en = cmp; cond_sel = 4'(c);
        br_en = br; pc_in = pc; br_ofs = ofs;
        #2;
        chk(flag_tag, "cc_flags", longint'(cc_flags), longint'(m_flags));
        exp_tk  = br && c <= 9 && ref_hit(m_flags, c);
        exp_bad = br && c > 9;
        d = ofs[9] ? longint'(ofs) - 1024 : longint'(ofs);
        exp_tgt = exp_tk ? 32'(longint'(pc) + 2 + 2 * d) : pc + 32'd2;
        ttag = !br ? "R11" : (c > 9 ? "R10" : btag);
        chk(ttag, "br_taken", longint'(br_taken), longint'(exp_tk));
        chk(ttag, "cond_bad", longint'(cond_bad), longint'(exp_bad));
        chk(exp_tk ? "R8" : "R9", "br_target", longint'(br_target), longint'(exp_tgt));
        if (cmp) begin
            m_flags  = ref_cmp(a, b);
            flag_tag = (a == b) ? "R2,R3" : "R2,R4";
        end else begin
            flag_tag = "R5";
        end
    endtask

    initial begin
        #(20000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1: reset value during and after reset
        repeat (3) @(negedge clk);
        #2 chk("R1", "cc_flags in reset", longint'(cc_flags), 0);
        rst_n = 1'b1;
        step(32'd0, 32'd0, 0, 0, 1, 32'h100, 10'd4, "R1");

        // R3: equal operands
        step(32'd7, 32'd7, 1, 0, 0, 32'h0, 10'd0, "R11");
        step(0, 0, 0, 0, 1, 32'h200, 10'd8, "R6");       // beq taken
        step(0, 0, 0, 1, 1, 32'h200, 10'd8, "R6");       // bne not taken
        for (int c = 6; c <= 9; c++) step(0, 0, 0, c, 1, 32'h300, 10'h3FF, "R7");
        // R4: -1 vs 1 => signed less, unsigned greater (0x0A)
        step(32'hFFFF_FFFF, 32'd1, 1, 0, 0, 32'h0, 10'd0, "R11");
        for (int c = 0; c <= 9; c++) step(0, 0, 0, c, 1, 32'h400, 10'h200, "R6");
        // R4: 1 vs -1 => signed greater, unsigned less (0x11)
        step(32'd1, 32'hFFFF_FFFF, 1, 0, 0, 32'h0, 10'd0, "R11");
        for (int c = 0; c <= 9; c++) step(0, 0, 0, c, 1, 32'hFFFF_FFFE, 10'h1FF, "R8");
        // R10: illegal selectors
        for (int c = 10; c <= 15; c++) step(0, 0, 0, c, 1, 32'h500, 10'd1, "R10");
        // R12: compare and branch in the same cycle use the old flags
        step(32'd5, 32'd5, 1, 1, 1, 32'h600, 10'd2, "R12");
        step(0, 0, 0, 0, 1, 32'h600, 10'd2, "R12");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = ($urandom_range(0, 3) == 0) ? a : 32'($urandom);
            if ($urandom_range(0, 3) == 0) b = {a[31:8], 8'($urandom)};
            step(a, b, $urandom_range(0, 2) == 0, $urandom_range(0, 15),
                 $urandom_range(0, 3) != 0, $urandom, 10'($urandom), "R6");
        end

        // R1: a second reset clears the flags
        @(negedge clk); rst_n = 1'b0; cmp_en = 1'b0; br_en = 1'b0;
        @(negedge clk); #2 chk("R1", "cc_flags after re-reset", longint'(cc_flags), 0);
        m_flags = '0; flag_tag = "R1"; rst_n = 1'b1;
        step(0, 0, 0, 2, 1, 32'h80, 10'd3, "R1");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule